// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small CPU core and turns a set of peripheral event flags into a single interrupt request and a 16-bit vector address. Fifteen maskable sources are used. One of them is a combined external-line/strobe source. Thirteen are dedicated peripheral sources. The last is a shared serial source that is fed by five serial event flags. Each maskable source is gated by its arm bit or bits and by the global mask I. A nonmaskable input is gated only by its own mask X. It outranks everything.

Software can pick one maskable source and promote it above the other maskable sources. Software can clear X, but it can never set X again. When the CPU pulses its acknowledge strobe, the block latches the winning vector and sets the mask bits. A restore strobe reloads both masks from saved copies, which models the return from a handler. The block never clears a peripheral flag. A request stays pending until its source drops it.

The X mask is held by a three-state machine, `xmask_state_t`:
- `XS_BOOT_HELD`: X=1 since reset.
- `XS_OPEN`: X=0, so the nonmaskable input is live.
- `XS_SVC_HELD`: X=1, set again by an acknowledge or a restore.

The transitions are:
- `T_SW_CLEAR`: a software clear. It goes from BOOT_HELD or SVC_HELD to OPEN.
- `T_NMI_ACCEPT`: an acknowledge while the nonmaskable input wins. It goes from OPEN to SVC_HELD.
- `T_RESTORE_SET`: a restore with saved X=1. It goes from OPEN to SVC_HELD.
- `T_RESTORE_CLEAR`: a restore with saved X=0. It goes from either held state to OPEN.
- In every other case the state holds.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, i_mask=1, x_mask=1, int_req=0, nmi_win=0, vec_now=0 and vec_held=0. The promotion selector is 0, which has no effect.
- R2: Maskable source k raises int_req only while its flag and arm are set and i_mask=0. For source 0, either irq_level=1 or (strobe_flag and strobe_arm) counts as its flag, and irq_level needs no arm. Sources 1..13 use per_flag[k-1] and per_arm[k-1].
- R3: The lowest-numbered pending maskable source wins, and vec_now = 16'hFFF2 - 2*k. For example, source 0 gives FFF2, source 1 gives FFF0 and source 14 gives FFD6. vec_now is 0 when nothing requests.
- R4: xirq with x_mask=0 sets nmi_win and int_req. It drives vec_now=16'hFFF4 above every maskable source, whatever i_mask is.
- R5: A promotion value p in 1..14, written by prom_wr with prom_sel, makes source p win over all other maskable sources while p is pending. Values 0 and 15 leave the fixed order unchanged.
- R6: Source 14 is the serial source. Its flag bits are sci_flag[0] receive-full, [1] overrun, [2] transmit-empty, [3] transmit-done and [4] idle. Receive-full and overrun share arm sci_arm[0]. The other three use sci_arm[1], [2] and [3]. All of them share vector FFD6.
- R7: cpu_ack while int_req=1 latches vec_now into vec_held and sets i_mask. If nmi_win=1, it also sets x_mask. cpu_ack while int_req=0 changes nothing.
- R8: mask_wr loads i_mask from mask_wr_i. It clears x_mask when mask_wr_x=0. It never sets x_mask.
- R9: rti_restore loads i_mask from saved_i and x_mask from saved_x.
- R10: In one cycle, an effective acknowledge overrides restore and mask_wr, and restore overrides mask_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_level | input | 1 | External level request, source 0 |
| strobe_flag | input | 1 | Parallel strobe flag, source 0 |
| strobe_arm | input | 1 | Arm for strobe flag |
| per_flag | input | 13 | Flags of sources 1..13 |
| per_arm | input | 13 | Arms of sources 1..13 |
| sci_flag | input | 5 | Serial event flags, source 14 |
| sci_arm | input | 4 | Serial arm bits |
| xirq | input | 1 | Nonmaskable request level |
| cpu_ack | input | 1 | CPU accepts current request |
| rti_restore | input | 1 | Reload masks from saved copies |
| saved_i | input | 1 | Saved I value |
| saved_x | input | 1 | Saved X value |
| mask_wr | input | 1 | Software mask write strobe |
| mask_wr_i | input | 1 | Written I value |
| mask_wr_x | input | 1 | Written X value |
| prom_wr | input | 1 | Promotion register write strobe |
| prom_sel | input | 4 | Source index to promote |
| int_req | output | 1 | Interrupt request to CPU |
| nmi_win | output | 1 | Nonmaskable input is the winner |
| vec_now | output | 16 | Vector of current winner |
| vec_held | output | 16 | Vector latched at last acknowledge |
| i_mask | output | 1 | Global maskable mask |
| x_mask | output | 1 | Nonmaskable mask |

## Verification
The hardest state to reach is the one where the nonmaskable input wins. It needs a prior software clear of X. The next acknowledge sets X again, and after that only a software clear or a restore with saved X=0 reopens it. The stimulus therefore mixes rare mask writes (often with X=0), restores with random saved values and frequent acknowledges. This keeps the machine cycling through all three states. Sparse random flags, together with random promotion writes, make priority ties and promoted wins common. A behavioural model compares every output each cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NPER    = 13;
    localparam int NMSK    = NPER + 2;
    localparam int IDX_W   = $clog2(NMSK + 1);
    localparam int VEC_W   = 16;
    localparam int SCI_N   = 5;
    localparam int SCI_A   = SCI_N - 1;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFF2;
    localparam logic [VEC_W-1:0] VEC_NMI = 16'hFFF4;

    typedef enum logic [1:0] {
        XS_BOOT_HELD = 2'd0,
        XS_OPEN      = 2'd1,
        XS_SVC_HELD  = 2'd2
    } xmask_state_t;
endpackage

// File: rtl/irqc_req_gate.sv
module irqc_req_gate
    import irqc_pkg::*;
(
    input  logic             i_mask,
    input  logic             irq_level,
    input  logic             strobe_flag,
    input  logic             strobe_arm,
    input  logic [NPER-1:0]  per_flag,
    input  logic [NPER-1:0]  per_arm,
    input  logic [SCI_N-1:0] sci_flag,
    input  logic [SCI_A-1:0] sci_arm,
    output logic [NMSK-1:0]  req
);
    logic [NMSK-1:0]  raw;
    logic [SCI_A-1:0] sci_hit;

    // receive-full and overrun share the first serial arm
    assign sci_hit[0] = (sci_flag[0] | sci_flag[1]) & sci_arm[0];
    for (genvar j = 2; j < SCI_N; j++) begin : g_sci
        assign sci_hit[j-1] = sci_flag[j] & sci_arm[j-1];
    end

    assign raw[0] = irq_level | (strobe_flag & strobe_arm);
    for (genvar k = 1; k <= NPER; k++) begin : g_per
        assign raw[k] = per_flag[k-1] & per_arm[k-1];
    end
    assign raw[NMSK-1] = |sci_hit;

    assign req = i_mask ? '0 : raw;
endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NMSK-1:0]   req,
    input  logic              xirq_req,
    input  logic [IDX_W-1:0]  prom_idx,
    output logic              valid,
    output logic              nmi,
    output logic [VEC_W-1:0]  vec
);
    logic [IDX_W-1:0] win_idx;
    logic             found;

    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int k = NMSK - 1; k >= 0; k--) begin
            if (req[k]) begin
                win_idx = IDX_W'(k);
                found   = 1'b1;
            end
        end
        for (int k = 0; k < NMSK; k++) begin
            if (IDX_W'(k) == prom_idx && req[k]) win_idx = IDX_W'(k);
        end
    end

    always_comb begin
        nmi   = xirq_req;
        valid = xirq_req | found;
        if (xirq_req)   vec = VEC_NMI;
        else if (found) vec = VEC_TOP - VEC_W'({win_idx, 1'b0});
        else            vec = '0;
    end

    p_nmi_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xirq_req |-> (vec == VEC_NMI && valid));
    p_idle_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && !xirq_req) |-> (vec == '0 && !valid));
endmodule

// File: rtl/irqc_mask_fsm.sv
module irqc_mask_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eff_ack,
    input  logic ack_nmi,
    input  logic rti_restore,
    input  logic saved_i,
    input  logic saved_x,
    input  logic mask_wr,
    input  logic mask_wr_i,
    input  logic mask_wr_x,
    output logic i_mask,
    output logic x_mask
);
    xmask_state_t state, state_nx;
    logic         i_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= XS_BOOT_HELD;
            i_mask <= 1'b1;
        end else begin
            state  <= state_nx;
            i_mask <= i_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            XS_BOOT_HELD, XS_SVC_HELD: begin
                if (eff_ack)                     state_nx = state;
                else if (rti_restore)            state_nx = saved_x ? state : XS_OPEN;
                else if (mask_wr && !mask_wr_x)  state_nx = XS_OPEN;
            end
            XS_OPEN: begin
                if (eff_ack)                     state_nx = ack_nmi ? XS_SVC_HELD : XS_OPEN;
                else if (rti_restore && saved_x) state_nx = XS_SVC_HELD;
            end
            default: state_nx = XS_BOOT_HELD;
        endcase
    end

    always_comb begin
        if (eff_ack)          i_nx = 1'b1;
        else if (rti_restore) i_nx = saved_i;
        else if (mask_wr)     i_nx = mask_wr_i;
        else                  i_nx = i_mask;
        x_mask = (state != XS_OPEN);
    end

    p_no_sw_xset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_mask && !eff_ack && !rti_restore) |=> !x_mask);
    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_restore && !eff_ack) |=> (i_mask == $past(saved_i) && x_mask == $past(saved_x)));
    p_ack_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eff_ack |=> i_mask);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_level,
    input  logic              strobe_flag,
    input  logic              strobe_arm,
    input  logic [NPER-1:0]   per_flag,
    input  logic [NPER-1:0]   per_arm,
    input  logic [SCI_N-1:0]  sci_flag,
    input  logic [SCI_A-1:0]  sci_arm,
    input  logic              xirq,
    input  logic              cpu_ack,
    input  logic              rti_restore,
    input  logic              saved_i,
    input  logic              saved_x,
    input  logic              mask_wr,
    input  logic              mask_wr_i,
    input  logic              mask_wr_x,
    input  logic              prom_wr,
    input  logic [IDX_W-1:0]  prom_sel,
    output logic              int_req,
    output logic              nmi_win,
    output logic [VEC_W-1:0]  vec_now,
    output logic [VEC_W-1:0]  vec_held,
    output logic              i_mask,
    output logic              x_mask
);
    logic [NMSK-1:0]  req;
    logic [IDX_W-1:0] prom_q;
    logic             eff_ack;

    irqc_req_gate u_gate (
        .i_mask(i_mask), .irq_level(irq_level), .strobe_flag(strobe_flag),
        .strobe_arm(strobe_arm), .per_flag(per_flag), .per_arm(per_arm),
        .sci_flag(sci_flag), .sci_arm(sci_arm), .req(req)
    );

    irqc_prio_sel u_prio (
        .clk(clk), .rst_n(rst_n), .req(req), .xirq_req(xirq & ~x_mask),
        .prom_idx(prom_q), .valid(int_req), .nmi(nmi_win), .vec(vec_now)
    );

    assign eff_ack = cpu_ack & int_req;

    irqc_mask_fsm u_mask (
        .clk(clk), .rst_n(rst_n), .eff_ack(eff_ack), .ack_nmi(nmi_win),
        .rti_restore(rti_restore), .saved_i(saved_i), .saved_x(saved_x),
        .mask_wr(mask_wr), .mask_wr_i(mask_wr_i), .mask_wr_x(mask_wr_x),
        .i_mask(i_mask), .x_mask(x_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prom_q   <= '0;
            vec_held <= '0;
        end else begin
            if (prom_wr) prom_q <= prom_sel;
            if (eff_ack) vec_held <= vec_now;
        end
    end

    p_ack_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && int_req) |=> (i_mask && vec_held == $past(vec_now)));
    p_nmi_ack_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && nmi_win) |=> x_mask);
    p_held_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ack && int_req) |=> $stable(vec_held));
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (i_mask && !nmi_win) |-> !int_req);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        irq_level = 0, strobe_flag = 0, strobe_arm = 0;
    logic [12:0] per_flag = '0, per_arm = '0;
    logic [4:0]  sci_flag = '0;
    logic [3:0]  sci_arm = '0;
    logic        xirq = 0, cpu_ack = 0, rti_restore = 0, saved_i = 0, saved_x = 0;
    logic        mask_wr = 0, mask_wr_i = 0, mask_wr_x = 0, prom_wr = 0;
    logic [3:0]  prom_sel = '0;
    logic        int_req, nmi_win, i_mask, x_mask;
    logic [15:0] vec_now, vec_held;

    int checks = 0, errors = 0;
    bit m_i = 1, m_x = 1;
    int m_prom = 0;
    logic [15:0] m_held = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs already driven; compare, then advance model
    task automatic step();
        int pend[$];
        bit e_nmi, e_req, eack;
        logic [15:0] e_vec;
        int w;
        #1;
        if (!m_i) begin
            if (irq_level || (strobe_flag && strobe_arm)) pend.push_back(0);
            for (int k = 1; k <= 13; k++)
                if (per_flag[k-1] && per_arm[k-1]) pend.push_back(k);
            if (((sci_flag[0] || sci_flag[1]) && sci_arm[0]) || (sci_flag[2] && sci_arm[1]) ||
                (sci_flag[3] && sci_arm[2]) || (sci_flag[4] && sci_arm[3])) pend.push_back(14);
        end
        e_nmi = xirq && !m_x;
        e_req = e_nmi || pend.size() > 0;
        if (e_nmi) e_vec = 16'hFFF4;
        else if (pend.size() > 0) begin
            w = pend[0];
            foreach (pend[q]) if (pend[q] == m_prom) w = m_prom;
            e_vec = 16'hFFF2 - 16'(2 * w);
        end else e_vec = 16'h0000;
        chk("R2 int_req", {15'd0, int_req}, {15'd0, e_req});
        chk("R4 nmi_win", {15'd0, nmi_win}, {15'd0, e_nmi});
        chk("R3/R5/R6 vec_now", vec_now, e_vec);
        chk("R7 vec_held", vec_held, m_held);
        chk("R8/R9/R10 i_mask", {15'd0, i_mask}, {15'd0, m_i});
        chk("R8/R9/R10 x_mask", {15'd0, x_mask}, {15'd0, m_x});
        eack = cpu_ack && e_req;
        @(posedge clk);
        #1;
        if (eack) begin
            m_held = e_vec; m_i = 1;
            if (e_nmi) m_x = 1;
        end else if (rti_restore) begin
            m_i = saved_i; m_x = saved_x;
        end else if (mask_wr) begin
            m_i = mask_wr_i;
            if (!mask_wr_x) m_x = 0;
        end
        if (prom_wr) m_prom = prom_sel;
    endtask

    task automatic idle();
        cpu_ack = 0; rti_restore = 0; mask_wr = 0; prom_wr = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        #1;
        chk("R1 i_mask", {15'd0, i_mask}, 16'd1);
        chk("R1 x_mask", {15'd0, x_mask}, 16'd1);
        chk("R1 int_req", {15'd0, int_req}, 16'd0);
        chk("R1 vec_now", vec_now, 16'h0000);
        chk("R1 vec_held", vec_held, 16'h0000);
        @(posedge clk); #1;
        // R2: armed flag while I=1 stays quiet, XIRQ blocked by X=1 (R4)
        per_flag = 13'h0001; per_arm = 13'h0001; xirq = 1;
        step();
        // R8: clear I and X, then try to set X again by software
        mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; step();
        mask_wr = 1; mask_wr_i = 0; mask_wr_x = 1; step();
        idle(); step();
        // R4/R7: nonmaskable wins and acknowledge sets both masks
        cpu_ack = 1; step(); idle(); step();
        // R9: restore reopens both masks
        rti_restore = 1; saved_i = 0; saved_x = 0; step(); idle(); xirq = 0; step();
        // R3: ordering; R5: promote source 12; R6: shared serial vector
        per_flag = 13'h1801; per_arm = 13'h1fff; step();
        prom_wr = 1; prom_sel = 4'd12; step(); idle(); step();
        per_flag = '0; sci_flag = 5'b00010; sci_arm = 4'b0001; step();
        sci_flag = 5'b10000; sci_arm = 4'b0111; step();
        sci_arm = 4'b1000; step();
        // R5: promotion value 15 has no effect
        prom_wr = 1; prom_sel = 4'd15; irq_level = 1; step(); idle(); step();
        // R10: ack beats restore and write in the same cycle
        cpu_ack = 1; rti_restore = 1; saved_i = 0; saved_x = 0;
        mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; step();
        // R10: restore beats write
        idle(); rti_restore = 1; saved_i = 0; saved_x = 1; mask_wr = 1; mask_wr_i = 1; mask_wr_x = 0;
        step(); idle(); irq_level = 0; step();
        // R7: ack with no request changes nothing
        sci_flag = 0; mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; step();
        idle(); cpu_ack = 1; step(); idle(); step();
        // mixed random traffic over all rules
        for (int n = 0; n < 4000; n++) begin
            irq_level   = ($urandom % 16) == 0;
            strobe_flag = ($urandom % 8) == 0;
            strobe_arm  = ($urandom % 2) == 0;
            for (int b = 0; b < 13; b++) begin
                per_flag[b] = ($urandom % 10) == 0;
                per_arm[b]  = ($urandom % 4) != 0;
            end
            sci_flag    = 5'($urandom) & 5'($urandom);
            sci_arm     = 4'($urandom);
            xirq        = ($urandom % 4) == 0;
            cpu_ack     = ($urandom % 3) == 0;
            rti_restore = ($urandom % 10) == 0;
            saved_i     = 1'($urandom);
            saved_x     = 1'($urandom);
            mask_wr     = ($urandom % 6) == 0;
            mask_wr_i   = ($urandom % 4) == 0;
            mask_wr_x   = 1'($urandom);
            prom_wr     = ($urandom % 12) == 0;
            prom_sel    = 4'($urandom);
            step();
        end
        finish_run();
    end
endmodule